// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Port

This block is an SPI master reached through a small 8-bit register port. Software writes a byte to the data register, and the block shifts it out MSB first on the serial output. At the same time it shifts a byte in from the serial input. The received byte is read back through that same data register. Both directions are buffered in 4-entry queues, so software can post up to four bytes before it has to wait. It can also leave up to four received bytes unread.

Clock polarity and phase are selected in the control register. The serial clock runs at the system clock divided by a power of two, from 2 to 4096. The divider code is split across two registers, and its code values are scrambled. Four chip-select lines are driven purely by software: each line has an enable bit and a level bit. An external mode-fault input raises a sticky error flag and an interrupt, and it drops the block out of master mode.

Top module: `spibyte_master`

## Requirements
- R1: After reset the registers read: control 0x51, status 0x05, extension 0x00, parameter 0x40, chip-select 0x00, timing 0x01. All chip-select lines are high, the interrupt is low and the serial clock is low.
- R2: Register offsets are control 0, status 1, data 2, extension 3, parameter 4, chip-select 5, timing 6. Read data appears on `rdata` in the cycle after `rd_en`, and writable registers read back what was written.
- R3: Chip-select line i drives bit i+4 of the chip-select register when bit i is 1, and drives high when bit i is 0. The lines change only in the cycle after a write to offset 5.
- R4: Each exchange is full duplex and 8 bits, MSB first. The byte written to the data register reaches the target, and the target's byte is the next byte read from the data register.
- R5: Control bit 3 (polarity) sets the idle level of the serial clock. Control bit 2 (phase) selects where data is captured: 0 captures on the leading edge with the first bit valid before it, and 1 launches on the leading edge and captures on the trailing edge. The serial output changes only together with a serial clock edge during an exchange.
- R6: The serial clock half period is 2^k system clocks. k comes from the code {extension[1:0], control[1:0]} as follows: codes 0,1,4,2,3 give k = 0,1,2,3,4, codes 5..11 give k = code, and codes 12..15 give k = 11.
- R7: While control bit 6 (enable) or control bit 4 (master) is 0, no exchange starts. A written byte stays queued (status bit 2, transmit empty, stays 0), and the serial clock rests at its idle level.
- R8: The transmit queue holds 4 bytes, and status bit 3 flags it full. A data write while it is full is dropped and sets sticky status bit 5, which is cleared by writing 1 to it.
- R9: A data read while the receive queue is empty (status bit 0) returns 0x00 and sets sticky status bit 6, which is cleared by writing 1 to it.
- R10: `mfault_i` high while enabled in master mode sets sticky status bit 7, drives `irq_o` high and clears control bit 4. Writing 1 to status bit 7 clears the flag and `irq_o`.
- R11: The receive queue holds 4 bytes in arrival order, and status bit 1 flags it full. A byte that completes while the queue is full is dropped and sets status bit 5. Status bit 4 reads 1 while an exchange is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Software chip-select lines |
| mfault_i | input | 1 | Mode-fault input |
| irq_o | output | 1 | Mode-fault interrupt |

## Verification
The bench drives every polarity and phase combination against a target model. It checks both bytes of each exchange and measures the serial half period, including a scrambled code and a clamped code. A wrong decode table would show up as a wrong measured half period, and a wrong sampling edge would show up as a shifted received byte. Four bytes are posted with the core disabled and then released in loopback, which checks queue order, the full flags and the dropping of a fifth byte. The bench also reads an empty receive queue, clears the sticky flags by writing 1, and injects a mode fault. After the fault it confirms that a new byte does not start.

// File: rtl/spibyte_pkg.sv
package spibyte_pkg;
  localparam int DIV_K_MAX = 11;

  localparam logic [2:0] A_CTL = 3'd0;
  localparam logic [2:0] A_STS = 3'd1;
  localparam logic [2:0] A_DAT = 3'd2;
  localparam logic [2:0] A_EXT = 3'd3;
  localparam logic [2:0] A_PRM = 3'd4;
  localparam logic [2:0] A_CSR = 3'd5;
  localparam logic [2:0] A_TIM = 3'd6;

  localparam logic [7:0] CTL_RST = 8'h51;
  localparam logic [7:0] EXT_RST = 8'h00;
  localparam logic [7:0] PRM_RST = 8'h40;
  localparam logic [7:0] TIM_RST = 8'h01;

  function automatic logic [3:0] div_k(input logic [3:0] code);
    case (code)
      4'd0: div_k = 4'd0;
      4'd1: div_k = 4'd1;
      4'd4: div_k = 4'd2;
      4'd2: div_k = 4'd3;
      4'd3: div_k = 4'd4;
      default: div_k = (code > 4'(DIV_K_MAX)) ? 4'(DIV_K_MAX) : code;
    endcase
  endfunction
endpackage

// File: rtl/spibyte_fifo.sv
module spibyte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/spibyte_shifter.sv
module spibyte_shifter #(
  parameter int W    = 8,
  parameter int CNTW = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         cpol,
  input  logic         cpha,
  input  logic [3:0]   k,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         sclk,
  output logic         mosi
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic [CNTW:0]   half;
  logic [CNTW-1:0] lim, cnt;
  logic [EW-1:0]   ecnt;
  logic [W-1:0]    sh, rsh;

  assign half    = {{CNTW{1'b0}}, 1'b1} << k;
  assign lim     = CNTW'(half - 1'b1);
  assign rx_byte = rsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      cnt  <= '0;
      ecnt <= '0;
      sh   <= '0;
      rsh  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy <= 1'b1;
          sh   <= tx_byte;
          cnt  <= '0;
          ecnt <= '0;
          if (!cpha) mosi <= tx_byte[W-1];
        end
      end else if (cnt == lim) begin
        cnt  <= '0;
        sclk <= ~sclk;
        ecnt <= ecnt + 1'b1;
        if (!ecnt[0]) begin
          if (!cpha) rsh <= {rsh[W-2:0], miso};
          else begin
            mosi <= sh[W-1];
            sh   <= sh << 1;
          end
        end else begin
          if (!cpha) begin
            mosi <= sh[W-2];
            sh   <= sh << 1;
          end else rsh <= {rsh[W-2:0], miso};
          if (ecnt == EW'(EDGES-1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spibyte_master.sv
module spibyte_master #(
  parameter int FIFO_DEPTH = 4,
  parameter int NCS        = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [2:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic           sclk_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_o,
  input  logic           mfault_i,
  output logic           irq_o
);
  import spibyte_pkg::*;

  localparam int DW   = 8;
  localparam int CNTW = DIV_K_MAX;

  logic [7:0] ctl_q, ext_q, prm_q, tim_q, cs_q;
  logic       ovf_q, udf_q, mf_q;
  logic       tx_empty, tx_full, rx_empty, rx_full;
  logic [DW-1:0] tx_head, rx_head, rx_byte;
  logic       eng_busy, eng_done, start;
  logic       dat_wr, dat_rd, sts_wr;
  logic [7:0] status;

  assign dat_wr = wr_en && (addr == A_DAT);
  assign dat_rd = rd_en && (addr == A_DAT);
  assign sts_wr = wr_en && (addr == A_STS);
  assign start  = !eng_busy && !tx_empty && ctl_q[6] && ctl_q[4];
  assign status = {mf_q, udf_q, ovf_q, eng_busy, tx_full, tx_empty, rx_full, rx_empty};

  spibyte_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .push(dat_wr), .din(wdata), .pop(start),
    .dout(tx_head), .empty(tx_empty), .full(tx_full));

  spibyte_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .push(eng_done), .din(rx_byte), .pop(dat_rd),
    .dout(rx_head), .empty(rx_empty), .full(rx_full));

  spibyte_shifter #(.W(DW), .CNTW(CNTW)) shift_i (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_head),
    .cpol(ctl_q[3]), .cpha(ctl_q[2]), .k(div_k({ext_q[1:0], ctl_q[1:0]})),
    .miso(miso_i), .busy(eng_busy), .done(eng_done), .rx_byte(rx_byte),
    .sclk(sclk_o), .mosi(mosi_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RST;
      ext_q <= EXT_RST;
      prm_q <= PRM_RST;
      tim_q <= TIM_RST;
      cs_q  <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      mf_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTL: ctl_q <= wdata;
          A_EXT: ext_q <= wdata;
          A_PRM: prm_q <= wdata;
          A_CSR: cs_q  <= wdata;
          A_TIM: tim_q <= wdata;
          default: ;
        endcase
      end
      if (sts_wr && wdata[5]) ovf_q <= 1'b0;
      if (sts_wr && wdata[6]) udf_q <= 1'b0;
      if (sts_wr && wdata[7]) mf_q  <= 1'b0;
      if ((dat_wr && tx_full) || (eng_done && rx_full)) ovf_q <= 1'b1;
      if (dat_rd && rx_empty) udf_q <= 1'b1;
      if (mfault_i && ctl_q[6] && ctl_q[4]) begin
        mf_q     <= 1'b1;
        ctl_q[4] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CTL: rdata <= ctl_q;
        A_STS: rdata <= status;
        A_DAT: rdata <= rx_empty ? 8'h00 : rx_head;
        A_EXT: rdata <= ext_q;
        A_PRM: rdata <= prm_q;
        A_CSR: rdata <= cs_q;
        A_TIM: rdata <= tim_q;
        default: rdata <= 8'h00;
      endcase
    end
  end

  assign irq_o = mf_q;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = cs_q[i] ? cs_q[i+NCS] : 1'b1;
  end
endmodule

// File: rtl/spibyte_master_chk.sv
module spibyte_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           rd_en,
  input logic [2:0]     addr,
  input logic [7:0]     wdata,
  input logic [7:0]     rdata,
  input logic [NCS-1:0] cs_o,
  input logic           irq_o,
  input logic           sclk_o,
  input logic           mosi_o,
  input logic           busy,
  input logic           cpol,
  input logic           rx_empty
);
  AST_CS_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 3'd5) |=> $stable(cs_o)); // R3

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sclk_o == $past(cpol))); // R7

  AST_MOSI_WITH_EDGE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mosi_o)) |-> !$stable(sclk_o)); // R5

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd2 && rx_empty) |=> (rdata == 8'h00)); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !(wr_en && addr == 3'd1 && wdata[7])) |=> irq_o); // R10
endmodule

bind spibyte_master spibyte_master_chk #(.NCS(NCS)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cs_o(cs_o), .irq_o(irq_o),
  .sclk_o(sclk_o), .mosi_o(mosi_o), .busy(eng_busy), .cpol(ctl_q[3]),
  .rx_empty(rx_empty));

// File: tb/spibyte_master_tb_top.sv
`timescale 1ns/1ps
module spibyte_master_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, mfault = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sclk, mosi, miso, irq;
  logic [3:0] cs;

  int checks = 0, failures = 0;
  bit finished = 0;
  longint cyc = 0;

  // target model state
  logic loop = 1'b0;
  logic m_cpol = 1'b0, m_cpha = 1'b0;
  logic [7:0] slv_byte = '0, slv_cap = '0;
  logic [2:0] slv_idx = '0;
  logic sclk_prev = 1'b0;
  longint edge_cyc = 0, half_last = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  assign miso = loop ? mosi : slv_byte[3'd7 - slv_idx];

  spibyte_master dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_o(cs), .mfault_i(mfault), .irq_o(irq));

  always @(negedge clk) begin
    if (!rst && sclk !== sclk_prev) begin
      logic lead;
      lead = (sclk != m_cpol);
      half_last = cyc - edge_cyc;
      edge_cyc  = cyc;
      if (lead != m_cpha) slv_cap = {slv_cap[6:0], mosi};
      if (!lead) slv_idx = slv_idx + 3'd1;
    end
    sclk_prev = sclk;
  end

  // stimulus: [21] cpol [20] cpha [19:16] divider code [15:8] tx [7:0] target byte
  localparam int NV = 7;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0,  8'hA5, 8'h3C},
    {1'b0, 1'b1, 4'd1,  8'h81, 8'h7E},
    {1'b1, 1'b0, 4'd4,  8'hC3, 8'h5A},
    {1'b1, 1'b1, 4'd2,  8'h0F, 8'hF0},
    {1'b0, 1'b1, 4'd3,  8'h96, 8'h01},
    {1'b1, 1'b0, 4'd8,  8'h80, 8'hFE},
    {1'b0, 1'b0, 4'd14, 8'h5B, 8'hC8}
  };

  function automatic int exp_k(input logic [3:0] c);
    case (c)
      4'd0: return 0;
      4'd1: return 1;
      4'd4: return 2;
      4'd2: return 3;
      4'd3: return 4;
      default: return (c > 4'd11) ? 11 : int'(c);
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_sts(input logic [7:0] mask, input logic [7:0] val);
    logic [7:0] s;
    for (int n = 0; n < 20000; n++) begin
      rd(3'd1, s);
      if ((s & mask) == val) return;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3_600_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R2 reset values and offsets
    check("R1 cs lines", cs, 4'hF);
    check("R1 irq", irq, 0);
    check("R1 sclk", sclk, 0);
    rd(3'd0, d); check("R1 R2 control", d, 8'h51);
    rd(3'd1, d); check("R1 R2 status", d, 8'h05);
    rd(3'd3, d); check("R1 R2 extension", d, 8'h00);
    rd(3'd4, d); check("R1 R2 parameter", d, 8'h40);
    rd(3'd5, d); check("R1 R2 chip-select", d, 8'h00);
    rd(3'd6, d); check("R1 R2 timing", d, 8'h01);

    // R3 chip selects: en=1011, level=0010 -> lines 3..0 = 0,1,1,0
    wr(3'd5, 8'h2B);
    check("R3 cs drive", cs, 4'b0110);
    rd(3'd5, d); check("R2 cs readback", d, 8'h2B);
    wr(3'd6, 8'h9C);
    rd(3'd6, d); check("R2 timing readback", d, 8'h9C);

    // R4 R5 R6 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      wr(3'd0, {4'h5, e[21], e[20], e[17:16]});
      wr(3'd3, {6'h0, e[19:18]});
      idle(3);
      check($sformatf("R5 idle level v%0d", v), sclk, e[21]);
      m_cpol = e[21]; m_cpha = e[20];
      slv_byte = e[7:0]; slv_idx = '0; slv_cap = '0;
      wr(3'd2, e[15:8]);
      wait_sts(8'h01, 8'h00);
      rd(3'd2, d);
      check($sformatf("R4 R5 rx byte v%0d", v), d, e[7:0]);
      check($sformatf("R4 target saw v%0d", v), slv_cap, e[15:8]);
      check($sformatf("R6 half period v%0d", v), half_last, longint'(1) << exp_k(e[19:16]));
    end

    // R7 disabled core holds bytes; R8 queue full and overflow
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h10);
    loop = 1'b1; m_cpol = 1'b0; m_cpha = 1'b0;
    idle(2);
    wr(3'd2, 8'hA1);
    idle(20);
    rd(3'd1, d);
    check("R7 no start when disabled", d, 8'h01);
    check("R7 sclk idle", sclk, 0);
    wr(3'd2, 8'hB2); wr(3'd2, 8'hC3); wr(3'd2, 8'hD4);
    rd(3'd1, d); check("R8 tx full flag", d, 8'h09);
    wr(3'd2, 8'hEE);
    rd(3'd1, d); check("R8 overflow flag", d, 8'h29);
    wr(3'd1, 8'h20);
    rd(3'd1, d); check("R8 overflow cleared", d, 8'h09);

    // R11 release: four bytes in loopback fill the receive queue
    wr(3'd0, 8'h50);
    wait_sts(8'h02, 8'h02);
    idle(4);
    rd(3'd1, d); check("R11 rx full", d, 8'h06);
    wr(3'd2, 8'hE5);
    wait_sts(8'h14, 8'h04);
    rd(3'd1, d); check("R11 dropped byte overflow", d, 8'h26);
    rd(3'd2, d); check("R11 order 0", d, 8'hA1);
    rd(3'd2, d); check("R11 order 1", d, 8'hB2);
    rd(3'd2, d); check("R11 order 2", d, 8'hC3);
    rd(3'd2, d); check("R11 order 3", d, 8'hD4);

    // R9 empty read
    rd(3'd2, d); check("R9 empty read data", d, 8'h00);
    rd(3'd1, d); check("R9 underflow flag", d, 8'h65);
    wr(3'd1, 8'h60);
    rd(3'd1, d); check("R8 R9 flags cleared", d, 8'h05);

    // R10 mode fault
    @(negedge clk); mfault = 1'b1;
    @(negedge clk); mfault = 1'b0;
    check("R10 irq raised", irq, 1);
    rd(3'd0, d); check("R10 master cleared", d, 8'h40);
    wr(3'd2, 8'h77);
    idle(20);
    rd(3'd1, d); check("R10 no start after fault", d, 8'h81);
    wr(3'd1, 8'h80);
    check("R10 irq cleared", irq, 0);
    check("R3 cs unchanged", cs, 4'b0110);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule